// File: doc/BRIEF.md
# Sv32 Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table held in memory. A requester presents an address and an access kind (instruction fetch, load or store) together with the current address-translation control word. The walker accepts one request at a time. When translation is off, it answers at once with the address unchanged. When translation is on, it reads one or two page table entries through a single-outstanding 32-bit read port. It then answers with either the translated address or a page fault and its cause code.

The control word carries the enable flag in bit 31 and the root table page number in bits 21:0. Bits 30:22 are an address-space tag that the walker ignores. A table entry carries its page number in bits 31:10: the upper part is bits 31:20 and the lower part is bits 19:10. Bits 3:0 are X, W, R and V. An entry is a leaf when any of X, W or R is set. The walker caches nothing, checks no permissions and never writes the tables back.

Top module: `sv32_walker`

## Requirements
- R1: When bit 31 of `satp` is 0 at acceptance, the response carries `rsp_paddr` equal to the accepted virtual address with no fault, no table read is issued, and `rsp_valid` rises one cycle after the accepting edge.
- R2: The first table read goes to (satp[21:0] × 4096 + VA[31:22] × 4), kept to its low 32 bits.
- R3: After a first-level entry with V=1 and X=W=R=0, the second read goes to (entry[31:10] × 4096 + VA[21:12] × 4), kept to its low 32 bits.
- R4: A valid first-level leaf whose bits 19:10 are zero maps a 4 MiB page: the address is {entry[31:20], VA[21:0]}, with the bits above bit 31 dropped.
- R5: A valid second-level leaf maps a 4 KiB page: the address is {entry[31:10], VA[11:0]}, with the bits above bit 31 dropped.
- R6: An entry with V=0 at either level ends the walk with `rsp_fault`=1 and `rsp_paddr`=0.
- R7: A second-level entry with V=1 and X=W=R=0 ends the walk with a fault.
- R8: A first-level leaf whose bits 19:10 are nonzero is a misaligned large page and ends the walk with a fault.
- R9: The fault cause is 12 for `req_type`=2'b00 (fetch), 13 for 2'b01 (load) and 15 for 2'b10 or 2'b11 (store). A response without a fault has cause 0.
- R10: `req_ready` is high only while the walker is idle. Each accepted request yields exactly one single-cycle `rsp_valid` pulse. The address, kind and control word are captured at acceptance, so later changes on those inputs have no effect on the walk.
- R11: At most one table read is outstanding. A read request held while `mem_req_ready` is low keeps its address stable.
- R12: With a read port that grants at once and returns data one cycle after the grant, a walk of N reads responds 1 + 2N cycles after the accepting edge. Each cycle of grant delay adds one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address |
| req_type | input | 2 | 00 fetch, 01 load, 1x store |
| satp | input | 32 | Translation control word (enable, tag, root page number) |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Table read granted |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Table read data present |
| mem_rsp_data | input | 32 | Table entry read |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Page fault flag |
| rsp_cause | output | 5 | Fault cause code |

## Verification
The bench takes the accepting edge as cycle 0. It expects `rsp_valid` in cycle 1 in bare mode, in cycle 3 after one table read and in cycle 5 after two reads, plus one cycle for each cycle the first read grant is held back. On every cycle before that point it checks that `rsp_valid` and `req_ready` are both low. It compares the result fields only in the cycle the response is due. It samples at the falling edge and records the table read addresses as they are granted, so both the count and the order of the reads are checked against the reference model.

// File: rtl/sv32_walk_pkg.sv
package sv32_walk_pkg;

  typedef enum logic [2:0] {
    IDLE, L1_REQ, L1_WAIT, L2_REQ, L2_WAIT, RESP
  } walk_state_e;

  typedef enum logic [1:0] {
    PTE_BAD, PTE_LEAF, PTE_NEXT
  } pte_kind_e;

  localparam logic [4:0] CAUSE_FETCH = 5'd12;
  localparam logic [4:0] CAUSE_LOAD  = 5'd13;
  localparam logic [4:0] CAUSE_STORE = 5'd15;

  function automatic logic [4:0] fault_cause(input logic [1:0] kind);
    case (kind)
      2'b00:   fault_cause = CAUSE_FETCH;
      2'b01:   fault_cause = CAUSE_LOAD;
      default: fault_cause = CAUSE_STORE;
    endcase
  endfunction

endpackage

// File: rtl/sv32_pte_addr.sv
module sv32_pte_addr #(
  parameter int ADDR_W = 32,
  parameter int PPN_W  = 22,
  parameter int VPN_W  = 10,
  parameter int OFS_W  = 12,
  parameter int PTE_LG = 2
) (
  input  logic [PPN_W-1:0]  root_ppn,
  input  logic [PPN_W-1:0]  next_ppn,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              second_level,
  output logic [ADDR_W-1:0] pte_addr
);
  localparam int FULL_W = PPN_W + OFS_W;
  localparam int PAD_W  = FULL_W - VPN_W - PTE_LG;

  logic [FULL_W-1:0] base, index, sum;
  logic [VPN_W-1:0]  vpn;

  always_comb begin
    base  = {(second_level ? next_ppn : root_ppn), {OFS_W{1'b0}}};
    vpn   = second_level ? vaddr[OFS_W +: VPN_W] : vaddr[OFS_W+VPN_W +: VPN_W];
    index = {{PAD_W{1'b0}}, vpn, {PTE_LG{1'b0}}};
    sum   = base + index;
    pte_addr = sum[ADDR_W-1:0];
  end
endmodule

// File: rtl/sv32_pte_decode.sv
module sv32_pte_decode
  import sv32_walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PTE_W  = 32,
  parameter int PPN_W  = 22,
  parameter int VPN_W  = 10,
  parameter int OFS_W  = 12
) (
  input  logic [PTE_W-1:0]       pte,
  input  logic [OFS_W+VPN_W-1:0] va_low,
  input  logic                   second_level,
  output pte_kind_e              kind,
  output logic [ADDR_W-1:0]      paddr,
  output logic [PPN_W-1:0]       next_ppn
);
  localparam int PPN_LSB = PTE_W - PPN_W;
  localparam int FULL_W  = PPN_W + OFS_W;

  logic [PPN_W-1:0]       ppn;
  logic [VPN_W-1:0]       ppn_lo;
  logic [PPN_W-VPN_W-1:0] ppn_hi;
  logic                   valid, leaf;
  logic [FULL_W-1:0]      full;
  logic                   unused_flags;

  assign unused_flags = ^pte[PPN_LSB-1:4];

  always_comb begin
    ppn    = pte[PPN_LSB +: PPN_W];
    ppn_lo = ppn[VPN_W-1:0];
    ppn_hi = ppn[PPN_W-1:VPN_W];
    valid  = pte[0];
    leaf   = |pte[3:1];
    if (!valid)                               kind = PTE_BAD;
    else if (leaf && !second_level && |ppn_lo) kind = PTE_BAD;
    else if (leaf)                            kind = PTE_LEAF;
    else if (second_level)                    kind = PTE_BAD;
    else                                      kind = PTE_NEXT;
    full     = second_level ? {ppn, va_low[OFS_W-1:0]} : {ppn_hi, va_low};
    paddr    = full[ADDR_W-1:0];
    next_ppn = ppn;
  end
endmodule

// File: rtl/sv32_walker.sv
module sv32_walker
  import sv32_walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SATP_W = 32,
  parameter int PTE_W  = 32,
  parameter int PPN_W  = 22,
  parameter int VPN_W  = 10,
  parameter int OFS_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [1:0]        req_type,
  input  logic [SATP_W-1:0] satp,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic [4:0]        rsp_cause
);
  localparam int LOW_W = OFS_W + VPN_W;

  walk_state_e       state;
  logic [ADDR_W-1:0] va_q;
  logic [1:0]        kind_q;
  logic [PPN_W-1:0]  root_q, next_q;
  pte_kind_e         dec_kind;
  logic [ADDR_W-1:0] dec_paddr;
  logic [PPN_W-1:0]  dec_next;
  logic              unused_asid;

  assign unused_asid = ^satp[SATP_W-2:PPN_W];

  assign req_ready     = (state == IDLE);
  assign mem_req_valid = (state == L1_REQ) || (state == L2_REQ);
  assign rsp_valid     = (state == RESP);

  sv32_pte_addr #(
    .ADDR_W(ADDR_W), .PPN_W(PPN_W), .VPN_W(VPN_W), .OFS_W(OFS_W), .PTE_LG(2)
  ) u_addr (
    .root_ppn(root_q), .next_ppn(next_q), .vaddr(va_q),
    .second_level(state == L2_REQ), .pte_addr(mem_req_addr)
  );

  sv32_pte_decode #(
    .ADDR_W(ADDR_W), .PTE_W(PTE_W), .PPN_W(PPN_W), .VPN_W(VPN_W), .OFS_W(OFS_W)
  ) u_dec (
    .pte(mem_rsp_data), .va_low(va_q[LOW_W-1:0]),
    .second_level(state == L2_WAIT), .kind(dec_kind),
    .paddr(dec_paddr), .next_ppn(dec_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= IDLE;
      va_q      <= '0;
      kind_q    <= '0;
      root_q    <= '0;
      next_q    <= '0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
      rsp_cause <= '0;
    end else begin
      case (state)
        IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          kind_q <= req_type;
          root_q <= satp[PPN_W-1:0];
          if (!satp[SATP_W-1]) begin
            rsp_paddr <= req_vaddr;
            rsp_fault <= 1'b0;
            rsp_cause <= '0;
            state     <= RESP;
          end else begin
            state <= L1_REQ;
          end
        end
        L1_REQ: if (mem_req_ready) state <= L1_WAIT;
        L2_REQ: if (mem_req_ready) state <= L2_WAIT;
        L1_WAIT, L2_WAIT: if (mem_rsp_valid) begin
          case (dec_kind)
            PTE_LEAF: begin
              rsp_paddr <= dec_paddr;
              rsp_fault <= 1'b0;
              rsp_cause <= '0;
              state     <= RESP;
            end
            PTE_NEXT: begin
              next_q <= dec_next;
              state  <= L2_REQ;
            end
            default: begin
              rsp_paddr <= '0;
              rsp_fault <= 1'b1;
              rsp_cause <= fault_cause(kind_q);
              state     <= RESP;
            end
          endcase
        end
        RESP:    state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sv32_walker_chk.sv
module sv32_walker_chk #(
  parameter int ADDR_W = 32,
  parameter int SATP_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic [1:0]        req_type,
  input logic [SATP_W-1:0] satp,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic              rsp_fault,
  input logic [4:0]        rsp_cause
);
  logic              busy, bare_txn;
  logic [ADDR_W-1:0] va_seen;
  logic [1:0]        kind_seen;
  logic [4:0]        want_cause;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      bare_txn  <= 1'b0;
      va_seen   <= '0;
      kind_seen <= '0;
    end else if (req_valid && req_ready) begin
      busy      <= 1'b1;
      bare_txn  <= !satp[SATP_W-1];
      va_seen   <= req_vaddr;
      kind_seen <= req_type;
    end else if (rsp_valid) begin
      busy     <= 1'b0;
      bare_txn <= 1'b0;
    end
  end

  always_comb
    want_cause = (kind_seen == 2'b00) ? 5'd12 : (kind_seen == 2'b01) ? 5'd13 : 5'd15;

  AST_BARE_NO_READ: assert property (@(posedge clk) disable iff (rst)
    bare_txn |-> !mem_req_valid); // R1
  AST_BARE_ECHO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && bare_txn) |-> (rsp_paddr == va_seen && !rsp_fault)); // R1
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0)); // R6
  AST_CAUSE_MAP: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_cause == want_cause)); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready); // R10
  AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> busy); // R10
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R10
  AST_READ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R11
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R11
endmodule

bind sv32_walker sv32_walker_chk #(.ADDR_W(ADDR_W), .SATP_W(SATP_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .req_type(req_type), .satp(satp),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
);

// File: tb/sv32_walker_tb.sv
module sv32_walker_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_type = '0;
  logic [31:0] satp = '0;
  logic        mem_req_valid;
  logic        mem_gnt = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic [4:0]  rsp_cause;

  int n_checks = 0;
  int n_err = 0;
  logic [31:0] pt_mem [int unsigned];
  logic [31:0] seen_q [$];

  always #10 clk = ~clk;

  sv32_walker u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_type(req_type), .satp(satp),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_gnt),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (pt_mem.exists(a)) return pt_mem[a];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (rst) mem_rsp_valid <= 1'b0;
    else     mem_rsp_valid <= mem_req_valid && mem_gnt;
    mem_rsp_data <= rd(mem_req_addr);
    if (!rst && mem_req_valid && mem_gnt) seen_q.push_back(mem_req_addr);
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  // Reference walk computed from the requirements
  task automatic ref_walk(input logic [31:0] va, input logic [1:0] kind,
                          input logic [31:0] sp, output logic [31:0] pa,
                          output bit flt, output logic [4:0] cs,
                          output int nrd, output logic [31:0] a0,
                          output logic [31:0] a1);
    logic [31:0] e;
    longint t;
    pa = 0; flt = 0; cs = 0; nrd = 0; a0 = 0; a1 = 0;
    if (!sp[31]) begin pa = va; return; end
    t = longint'(sp[21:0]) * 4096 + longint'(va[31:22]) * 4;
    a0 = t[31:0]; nrd = 1; e = rd(a0);
    if (!e[0]) flt = 1;
    else if (e[3:1] != 0) begin
      if (e[19:10] != 0) flt = 1;
      else begin t = (longint'(e[31:20]) << 22) | longint'(va[21:0]); pa = t[31:0]; end
    end else begin
      t = longint'(e[31:10]) * 4096 + longint'(va[21:12]) * 4;
      a1 = t[31:0]; nrd = 2; e = rd(a1);
      if (!e[0] || e[3:1] == 0) flt = 1;
      else begin t = (longint'(e[31:10]) << 12) | longint'(va[11:0]); pa = t[31:0]; end
    end
    if (flt) cs = (kind == 2'b00) ? 5'd12 : (kind == 2'b01) ? 5'd13 : 5'd15;
  endtask

  task automatic run_case(input logic [31:0] va, input logic [1:0] kind,
                          input logic [31:0] sp, input int stall, input string tag);
    logic [31:0] pa, a0, a1;
    bit flt;
    logic [4:0] cs;
    int nrd, lat;
    ref_walk(va, kind, sp, pa, flt, cs, nrd, a0, a1);
    lat = (nrd == 0) ? 1 : 1 + 2 * nrd + stall;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready when idle", {31'b0, req_ready}, 32'h1);
    seen_q.delete();
    req_valid = 1'b1; req_vaddr = va; req_type = kind; satp = sp;
    mem_gnt = (stall == 0);
    @(posedge clk);
    for (int n = 1; n <= lat; n++) begin
      @(negedge clk);
      if (n > stall) mem_gnt = 1'b1;
      if (n == 1) begin req_vaddr = ~va; satp = ~sp; req_type = ~kind; end
      if (n < lat) begin
        chk(rsp_valid == 1'b0, "R12", "early response", {31'b0, rsp_valid}, 32'h0);
        chk(req_ready == 1'b0, "R10", "ready while busy", {31'b0, req_ready}, 32'h0);
      end else begin
        chk(rsp_valid == 1'b1, "R12", "response due", {31'b0, rsp_valid}, 32'h1);
        chk(rsp_fault == flt, tag, "fault", {31'b0, rsp_fault}, {31'b0, flt});
        chk(rsp_paddr == pa, tag, "paddr", rsp_paddr, pa);
        chk(rsp_cause == cs, "R9", "cause", {27'b0, rsp_cause}, {27'b0, cs});
      end
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10", "single pulse", {31'b0, rsp_valid}, 32'h0);
    chk(seen_q.size() == nrd, "R11", "read count", seen_q.size(), nrd);
    if (nrd >= 1 && seen_q.size() >= 1)
      chk(seen_q[0] == a0, "R2", "first read addr", seen_q[0], a0);
    if (nrd == 2 && seen_q.size() >= 2)
      chk(seen_q[1] == a1, "R3", "second read addr", seen_q[1], a1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL R12 watchdog: actual=%h expected=%h", 32'h1, 32'h0);
    summary();
    $finish;
  end

  localparam logic [31:0] SP_ON = 32'h8140_0100; // root page 0x100, tag bits set

  initial begin
    pt_mem[32'h0010_0004] = 32'h2AB0_0003; // large page leaf
    pt_mem[32'h0010_0008] = 32'h0008_0001; // pointer to table 0x200000
    pt_mem[32'h0020_0014] = 32'hF03D_400B; // small page leaf
    pt_mem[32'h0020_001C] = 32'h0000_0401; // pointer at second level
    pt_mem[32'h0010_0010] = 32'h0010_0407; // misaligned large page
    pt_mem[32'h0010_0FFC] = 32'hFFF0_0007; // large page, top bits dropped
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(req_ready == 1'b1, "R10", "reset ready", {31'b0, req_ready}, 32'h1);
    chk(rsp_valid == 1'b0, "R10", "reset rsp", {31'b0, rsp_valid}, 32'h0);
    chk(mem_req_valid == 1'b0, "R11", "reset read", {31'b0, mem_req_valid}, 32'h0);

    run_case(32'h1234_5678, 2'b01, 32'h7FFF_FFFF, 0, "R1");
    run_case(32'h0040_1234, 2'b01, SP_ON, 0, "R4");
    run_case(32'h0080_5678, 2'b00, SP_ON, 0, "R5");
    run_case(32'h00C0_0000, 2'b00, SP_ON, 0, "R6");
    run_case(32'h0080_6000, 2'b10, SP_ON, 0, "R6");
    run_case(32'h0080_7000, 2'b01, SP_ON, 0, "R7");
    run_case(32'h0100_0000, 2'b11, SP_ON, 0, "R8");
    run_case(32'hFFC0_0ABC, 2'b01, SP_ON, 0, "R4");
    run_case(32'h0080_5ABC, 2'b10, SP_ON, 3, "R11");
    run_case(32'hDEAD_BEEF, 2'b10, 32'h0000_0100, 0, "R1");

    summary();
    $finish;
  end
endmodule